// File: doc/BRIEF.md
# CPU Interrupt Recognition Unit

This block sits between the external interrupt request pins and the instruction sequencer of a processor core. At each decision point it picks which pending event the core takes. A decision point is an instruction boundary strobe, or a recognition window strobe between the single memory moves of a repeated string operation. There are three request sources. The system-management request has the highest priority and is not vectored through the descriptor table. The non-maskable request comes next and always uses the fixed internal vector 2, with no acknowledge cycle. The maskable request comes last. It is gated by the interrupt-enable flag and gets its vector from an acknowledge handshake.

The unit follows the non-maskable handler from entry to its matching return. While that handler runs, a new non-maskable request is held back, and only one rising edge is remembered for service after the return. Maskable interrupts stay serviceable inside that handler. A nesting counter makes sure that the return of a nested maskable handler does not end the non-maskable in-service state. The unit also produces the wake-up pulse for a halted core. Inside the non-maskable handler a new non-maskable edge does not wake the core.

Top module: `irq_recog_unit`

## Requirements
- R1: When several requests are eligible at one decision point, system-management (type code 1) is taken first, then non-maskable (type code 2), then maskable (type code 3). Type code 0 means no event.
- R2: A non-maskable take pulses take_o for one cycle with type 2 and vector 2, and no acknowledge request is raised for it.
- R3: After a non-maskable take, no further non-maskable take happens until the IRET that matches it.
- R4: Any number of non-maskable rising edges during the blocked period leave exactly one request. That request is taken at the first decision point after the matching IRET, and there is only one take.
- R5: A maskable request is serviced inside the non-maskable handler. The IRET of that nested handler does not end the non-maskable in-service state; only the next IRET does.
- R6: The maskable request is level-sensitive and is accepted only when intr_i and if_flag_i are both 1 at a decision point.
- R7: Accepting a maskable request raises ack_req_o in the next cycle. ack_req_o then holds until vec_valid_i. In the cycle after vec_valid_i, take_o pulses with type 3 and vector_o equal to vec_i. No other event is taken while ack_req_o is high.
- R8: Events are taken only at a cycle with boundary_i or str_window_i high. Either strobe alone is enough.
- R9: After halt_i, wake_o pulses for one cycle on an SMI, on an unmasked INTR, or on a non-maskable edge outside the handler. A non-maskable edge while in the handler does not wake the core.
- R10: A system-management take pulses take_o with type 1 and vector 0, and no acknowledge request is raised for it.
- R11: Reset clears all outputs, the pending request, the in-service state and the halted state.
- R12: nmi_i is edge-triggered through a two-flop synchroniser. A level held high for many cycles yields a single request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request pin, asynchronous |
| intr_i | input | 1 | Maskable request level |
| smi_i | input | 1 | System-management request level |
| if_flag_i | input | 1 | Interrupt-enable flag |
| boundary_i | input | 1 | Instruction boundary strobe |
| str_window_i | input | 1 | String-iteration recognition window strobe |
| iret_i | input | 1 | IRET executed |
| halt_i | input | 1 | HALT executed |
| vec_valid_i | input | 1 | Acknowledge vector valid |
| vec_i | input | 8 | Vector returned by the acknowledge cycle |
| take_o | output | 1 | Take-interrupt pulse |
| type_o | output | 2 | Event type: 0 none, 1 SMI, 2 NMI, 3 INTR |
| vector_o | output | 8 | Vector number of the taken event |
| ack_req_o | output | 1 | Acknowledge cycle request |
| wake_o | output | 1 | Wake pulse for a halted core |

## Verification
The hardest state to reach is a nested maskable handler inside the non-maskable handler with a fresh non-maskable edge already pending. Only a correct nesting count keeps that edge blocked across the inner IRET and releases it after the outer one. The stimulus enters the handler, runs a maskable acknowledge to completion, raises another edge, and then issues the two returns with decision strobes after each one. A separate sequence halts the core inside the handler and shows that an edge leaves it asleep while an unmasked INTR wakes it.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    IRQ_NONE = 2'd0,
    IRQ_SMI  = 2'd1,
    IRQ_NMI  = 2'd2,
    IRQ_INTR = 2'd3
  } irq_type_e;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= d_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/irq_nmi_track.sv
module irq_nmi_track #(
  parameter int NEST_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic take_nmi_i,
  input  logic intr_done_i,
  input  logic iret_i,
  output logic pend_o,
  output logic in_svc_o
);
  localparam logic [NEST_W-1:0] NEST_MAX = '1;

  logic              pend_q, svc_q;
  logic [NEST_W-1:0] nest_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      svc_q  <= 1'b0;
      nest_q <= '0;
    end else begin
      // one-deep latch: a new edge survives the take in the same cycle
      pend_q <= rise_i | (pend_q & ~take_nmi_i);
      if (take_nmi_i) begin
        svc_q  <= 1'b1;
        nest_q <= '0;
      end else if (svc_q) begin
        if (iret_i && !intr_done_i) begin
          if (nest_q == '0) svc_q  <= 1'b0;
          else              nest_q <= nest_q - 1'b1;
        end else if (intr_done_i && !iret_i && nest_q != NEST_MAX) begin
          nest_q <= nest_q + 1'b1;
        end
      end
    end
  end

  assign pend_o   = pend_q;
  assign in_svc_o = svc_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int              VEC_W   = 8,
  parameter logic [VEC_W-1:0] NMI_VEC = 2,
  parameter logic [VEC_W-1:0] SMI_VEC = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dp_i,
  input  logic             smi_i,
  input  logic             nmi_ok_i,
  input  logic             intr_ok_i,
  input  logic             vec_valid_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic             take_o,
  output irq_type_e        type_o,
  output logic [VEC_W-1:0] vector_o,
  output logic             ack_req_o,
  output logic             take_nmi_o,
  output logic             intr_done_o
);
  logic ack_q;

  assign take_nmi_o  = ~ack_q & dp_i & ~smi_i & nmi_ok_i;
  assign intr_done_o = ack_q & vec_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q    <= 1'b0;
      take_o   <= 1'b0;
      type_o   <= IRQ_NONE;
      vector_o <= '0;
    end else begin
      take_o   <= 1'b0;
      type_o   <= IRQ_NONE;
      vector_o <= '0;
      if (ack_q) begin
        if (vec_valid_i) begin
          ack_q    <= 1'b0;
          take_o   <= 1'b1;
          type_o   <= IRQ_INTR;
          vector_o <= vec_i;
        end
      end else if (dp_i) begin
        if (smi_i) begin
          take_o   <= 1'b1;
          type_o   <= IRQ_SMI;
          vector_o <= SMI_VEC;
        end else if (nmi_ok_i) begin
          take_o   <= 1'b1;
          type_o   <= IRQ_NMI;
          vector_o <= NMI_VEC;
        end else if (intr_ok_i) begin
          ack_q <= 1'b1;
        end
      end
    end
  end

  assign ack_req_o = ack_q;
endmodule

// File: rtl/irq_recog_unit.sv
module irq_recog_unit
  import irq_pkg::*;
#(
  parameter int VEC_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int NEST_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             nmi_i,
  input  logic             intr_i,
  input  logic             smi_i,
  input  logic             if_flag_i,
  input  logic             boundary_i,
  input  logic             str_window_i,
  input  logic             iret_i,
  input  logic             halt_i,
  input  logic             vec_valid_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic             take_o,
  output logic [1:0]       type_o,
  output logic [VEC_W-1:0] vector_o,
  output logic             ack_req_o,
  output logic             wake_o
);
  logic      nmi_rise, nmi_pend, nmi_svc, take_nmi, intr_done;
  logic      intr_ok, dp, wake_cond, halted_q, wake_q;
  irq_type_e type_w;

  assign dp      = boundary_i | str_window_i;
  assign intr_ok = intr_i & if_flag_i;

  irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(nmi_i), .rise_o(nmi_rise)
  );

  irq_nmi_track #(.NEST_W(NEST_W)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_i     (nmi_rise),
    .take_nmi_i (take_nmi),
    .intr_done_i(intr_done),
    .iret_i     (iret_i),
    .pend_o     (nmi_pend),
    .in_svc_o   (nmi_svc)
  );

  irq_arbiter #(.VEC_W(VEC_W)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dp_i       (dp),
    .smi_i      (smi_i),
    .nmi_ok_i   (nmi_pend & ~nmi_svc),
    .intr_ok_i  (intr_ok),
    .vec_valid_i(vec_valid_i),
    .vec_i      (vec_i),
    .take_o     (take_o),
    .type_o     (type_w),
    .vector_o   (vector_o),
    .ack_req_o  (ack_req_o),
    .take_nmi_o (take_nmi),
    .intr_done_o(intr_done)
  );

  assign type_o = type_w;

  // inside the NMI handler a fresh NMI edge does not restart the core
  assign wake_cond = smi_i | intr_ok | (nmi_rise & ~nmi_svc);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halted_q <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      wake_q <= halted_q & wake_cond;
      if (halted_q && wake_cond) halted_q <= 1'b0;
      else if (halt_i)           halted_q <= 1'b1;
    end
  end

  assign wake_o = wake_q;
endmodule

// File: rtl/irq_recog_chk.sv
module irq_recog_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             intr_i,
  input logic             if_flag_i,
  input logic             boundary_i,
  input logic             str_window_i,
  input logic             vec_valid_i,
  input logic [VEC_W-1:0] vec_i,
  input logic             take_o,
  input logic [1:0]       type_o,
  input logic [VEC_W-1:0] vector_o,
  input logic             ack_req_o,
  input logic             wake_o
);
  // R2
  nmi_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && type_o == 2'd2) |-> (vector_o == 2 && !ack_req_o));

  // R10
  smi_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && type_o == 2'd1) |-> (vector_o == 0 && !ack_req_o));

  // R7
  ack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_req_o && !vec_valid_i) |=> ack_req_o);

  // R7
  ack_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_req_o && vec_valid_i) |=> (take_o && type_o == 2'd3 && vector_o == $past(vec_i) && !ack_req_o));

  // R7
  ack_no_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_req_o |-> !take_o);

  // R6
  ack_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_req_o) |-> $past(intr_i && if_flag_i && (boundary_i || str_window_i)));

  // R8
  take_point_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && type_o != 2'd3) |-> $past(boundary_i || str_window_i));

  // R9
  wake_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  // R1
  type_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> type_o != 2'd0);
endmodule

bind irq_recog_unit irq_recog_chk #(.VEC_W(VEC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .intr_i      (intr_i),
  .if_flag_i   (if_flag_i),
  .boundary_i  (boundary_i),
  .str_window_i(str_window_i),
  .vec_valid_i (vec_valid_i),
  .vec_i       (vec_i),
  .take_o      (take_o),
  .type_o      (type_o),
  .vector_o    (vector_o),
  .ack_req_o   (ack_req_o),
  .wake_o      (wake_o)
);

// File: tb/tb_irq_recog_unit.sv
`timescale 1ns/1ps
module tb_irq_recog_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic nmi = 0, intr = 0, smi = 0, ifl = 0, bnd = 0, win = 0, iret = 0, halt = 0, vvalid = 0;
  logic [7:0] vec = 0;
  logic take, ack, wake;
  logic [1:0] typ;
  logic [7:0] vout;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R11";
  int cnt_nmi = 0, cnt_smi = 0, cnt_intr = 0, cnt_wake = 0;
  int last_intr_vec = -1, last_smi_vec = -1, last_nmi_vec = -1;

  always #2 clk = ~clk;

  irq_recog_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .nmi_i(nmi), .intr_i(intr), .smi_i(smi),
    .if_flag_i(ifl), .boundary_i(bnd), .str_window_i(win), .iret_i(iret),
    .halt_i(halt), .vec_valid_i(vvalid), .vec_i(vec), .take_o(take),
    .type_o(typ), .vector_o(vout), .ack_req_o(ack), .wake_o(wake)
  );

  // behavioural reference
  bit sq0, sq1, prv, mpend, msvc, mack, mhalt;
  int mnest;
  bit e_take, e_ack, e_wake;
  int e_type, e_vec;
  bit m_e, m_dp, m_tn, m_id, m_wc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq0 = 0; sq1 = 0; prv = 0; mpend = 0; msvc = 0; mack = 0; mhalt = 0; mnest = 0;
      e_take = 0; e_ack = 0; e_wake = 0; e_type = 0; e_vec = 0;
    end else begin
      m_e = sq1 && !prv;
      m_dp = bnd || win;
      m_tn = 0; m_id = 0;
      e_take = 0; e_type = 0; e_vec = 0;
      if (mack) begin
        if (vvalid) begin e_take = 1; e_type = 3; e_vec = vec; mack = 0; m_id = 1; end
      end else if (m_dp) begin
        if (smi) begin e_take = 1; e_type = 1; e_vec = 0; end
        else if (mpend && !msvc) begin e_take = 1; e_type = 2; e_vec = 2; m_tn = 1; end
        else if (intr && ifl) mack = 1;
      end
      e_ack = mack;
      m_wc = mhalt && (smi || (intr && ifl) || (m_e && !msvc));
      e_wake = m_wc;
      if (m_wc) mhalt = 0; else if (halt) mhalt = 1;
      mpend = m_e || (mpend && !m_tn);
      if (m_tn) begin msvc = 1; mnest = 0; end
      else if (msvc) begin
        if (iret && !m_id) begin if (mnest == 0) msvc = 0; else mnest--; end
        else if (m_id && !iret && mnest < 15) mnest++;
      end
      prv = sq1; sq1 = sq0; sq0 = nmi;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk({take, typ, vout, ack, wake} == {e_take, e_type[1:0], e_vec[7:0], e_ack, e_wake},
          cur_req, {take, typ, vout, ack, wake}, {e_take, e_type[1:0], e_vec[7:0], e_ack, e_wake});
      if (take) case (typ)
        2'd1: begin cnt_smi++;  last_smi_vec = vout; end
        2'd2: begin cnt_nmi++;  last_nmi_vec = vout; end
        2'd3: begin cnt_intr++; last_intr_vec = vout; end
        default: ;
      endcase
      if (wake) cnt_wake++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL R11 watchdog act=%0d exp=%0d", cycles, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask
  task automatic strobe();
    bnd = 1; tick(1); bnd = 0; tick(1);
  endtask
  task automatic do_iret();
    iret = 1; tick(1); iret = 0; tick(1);
  endtask
  task automatic nmi_pulse();
    nmi = 1; tick(3); nmi = 0; tick(2);
  endtask
  task automatic vec_ret(input logic [7:0] v);
    vec = v; vvalid = 1; tick(1); vvalid = 0; tick(1);
  endtask

  int b;

  initial begin
    tick(3);
    // R11 reset state
    chk({take, typ, vout, ack, wake} == 0, "R11", {take, typ, vout, ack, wake}, 0);
    rst_n = 1; tick(2);

    // R8: no decision point, no acceptance
    cur_req = "R8"; intr = 1; ifl = 1; tick(5);
    chk(ack == 0, "R8", ack, 0);
    strobe();
    cur_req = "R7"; chk(ack == 1, "R7", ack, 1);
    smi = 1; strobe(); smi = 0; tick(2);
    b = cnt_smi; chk(cnt_smi == 0, "R7", cnt_smi, 0);
    intr = 0; vec_ret(8'h41);
    chk(cnt_intr == 1 && last_intr_vec == 'h41, "R7", last_intr_vec, 'h41);

    // R6: masked INTR ignored
    cur_req = "R6"; ifl = 0; intr = 1; strobe(); tick(2);
    chk(ack == 0 && cnt_intr == 1, "R6", ack, 0);
    intr = 0; ifl = 1;

    // R12/R2: held NMI level yields one request
    cur_req = "R12"; nmi = 1; tick(4); strobe(); tick(2); strobe(); strobe(); nmi = 0; tick(2);
    chk(cnt_nmi == 1, "R12", cnt_nmi, 1);
    chk(last_nmi_vec == 2, "R2", last_nmi_vec, 2);

    // R3: blocked until IRET
    cur_req = "R3"; nmi_pulse(); strobe(); strobe();
    chk(cnt_nmi == 1, "R3", cnt_nmi, 1);

    // R4: several edges, one request after IRET
    cur_req = "R4"; nmi_pulse(); nmi_pulse(); do_iret(); strobe(); strobe(); strobe();
    chk(cnt_nmi == 2, "R4", cnt_nmi, 2);
    do_iret(); strobe();
    chk(cnt_nmi == 2, "R4", cnt_nmi, 2);

    // R5: nested INTR inside NMI handler
    cur_req = "R5"; nmi_pulse(); strobe();
    chk(cnt_nmi == 3, "R5", cnt_nmi, 3);
    intr = 1; strobe(); intr = 0; tick(2); vec_ret(8'h5A);
    chk(cnt_intr == 2 && last_intr_vec == 'h5A, "R5", last_intr_vec, 'h5A);
    do_iret(); nmi_pulse(); strobe();
    chk(cnt_nmi == 3, "R5", cnt_nmi, 3);
    do_iret(); strobe();
    chk(cnt_nmi == 4, "R5", cnt_nmi, 4);
    do_iret();

    // R1: priority SMI > NMI > INTR
    cur_req = "R1"; nmi_pulse(); smi = 1; intr = 1; strobe(); smi = 0;
    chk(cnt_smi == 1 && cnt_nmi == 4, "R1", cnt_smi, 1);
    chk(last_smi_vec == 0, "R10", last_smi_vec, 0);
    strobe();
    chk(cnt_nmi == 5 && ack == 0, "R1", cnt_nmi, 5);
    do_iret(); strobe(); intr = 0;
    chk(ack == 1, "R1", ack, 1);
    vec_ret(8'h21);
    chk(cnt_intr == 3, "R1", cnt_intr, 3);

    // R8: string window alone is a decision point
    cur_req = "R8"; smi = 1; win = 1; tick(1); win = 0; smi = 0; tick(1);
    chk(cnt_smi == 2, "R8", cnt_smi, 2);

    // R9: wake rules
    cur_req = "R9"; halt = 1; tick(1); halt = 0; tick(2); nmi_pulse();
    chk(cnt_wake == 1, "R9", cnt_wake, 1);
    strobe(); do_iret();                       // consume that edge
    nmi_pulse(); strobe();                     // enter handler
    chk(cnt_nmi == 7, "R9", cnt_nmi, 7);
    halt = 1; tick(1); halt = 0; tick(1); nmi_pulse(); tick(3);
    chk(cnt_wake == 1, "R9", cnt_wake, 1);
    intr = 1; tick(1); intr = 0; tick(2);
    chk(cnt_wake == 2, "R9", cnt_wake, 2);
    halt = 1; tick(1); halt = 0; tick(2); smi = 1; tick(1); smi = 0; tick(2);
    chk(cnt_wake == 3, "R9", cnt_wake, 3);

    // R11: reset clears pending and in-service state
    cur_req = "R11"; nmi_pulse();              // pending while in handler
    rst_n = 0; tick(2);
    chk({take, typ, vout, ack, wake} == 0, "R11", {take, typ, vout, ack, wake}, 0);
    rst_n = 1; tick(2); strobe(); strobe();
    chk(cnt_nmi == 7, "R11", cnt_nmi, 7);
    nmi_pulse(); strobe();
    chk(cnt_nmi == 8, "R11", cnt_nmi, 8);
    tick(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule